// File: doc/BRIEF.md
# Ring Input Packet Stripper with Echo Insertion

This block sits on the receive side of a node on a unidirectional symbol ring. It watches the incoming stream of 16-bit symbols, finds packet boundaries, and reads the first three header symbols of every packet: target node, command and sender node. A packet aimed at some other node continues downstream on the bypass output. A data packet aimed at this node is pulled off the ring. If the local input buffer has room for the whole packet, the packet is written into that buffer and a 4-symbol acknowledge echo goes back to the sender. If there is no room, the packet is dropped and the echo carries a negative status. The rest of the stripped packet's slots become idle symbols, which lets bypass buffers further down the ring drain.

An echo packet aimed at this node is also removed from the ring. Its status and the identity of the node that sent it are reported to the transmit logic on a one-cycle strobe. Each input symbol comes with a flag that marks it as part of a packet (1) or as an idle (0). Every packet is preceded by at least one idle. The whole stream passes through a three-stage header delay line, so the strip/forward decision is made before the first symbol of the packet leaves the block.

Top module: `ring_strip_echo`

## Requirements
- R1: While reset is held, and before any packet has passed, `byp_pkt`, `byp_sym`, `buf_wr` and `echo_vld` are all zero.
- R2: A packet whose target (header symbol 0) differs from `node_id` appears on `byp_pkt`/`byp_sym` unchanged, one symbol for each input symbol, 3 + OUT_REG cycles after it was presented. It is never written to the input buffer.
- R3: Every output position that is not a packet symbol has `byp_pkt` = 0 and `byp_sym` = 0, whatever data the input idle carried.
- R4: The packet length comes from bits [1:0] of header symbol 1: 00 gives 4 symbols, 01 gives 8, 10 gives 16 and 11 gives 40. A stripped data packet produces an echo in its first four output positions. Its remaining length−4 positions are idle.
- R5: An echo is laid out as follows. Symbol 0 is the sender id taken from header symbol 2 of the stripped packet. Symbol 1 has bit 4 set for nack, bits [1:0] = 00 and all other bits zero. Symbol 2 is `node_id`. Symbol 3 is zero.
- R6: A data packet (code ≠ 00) aimed at `node_id` is accepted when `buf_space` ≥ its length in the cycle its header symbol 2 is presented. The echo then carries ack, and every symbol of the packet is written in order to `buf_data` with `buf_wr`, 3 cycles after input. `buf_sop` is high only on the first symbol.
- R7: When `buf_space` is below the packet length at that point, the echo carries nack and nothing of the packet is written. The case `buf_space` = length − 1 is a nack.
- R8: An echo (code 00) aimed at `node_id` leaves only idles on the ring and is not written to the buffer. `echo_vld` pulses for one cycle, 3 cycles after the echo's symbol 0 was presented. With the pulse, `echo_nack` equals bit 4 of its symbol 1 and `echo_from` equals its symbol 2.
- R9: Packets separated by a single idle are each classified and handled independently, including a stripped packet followed at once by a forwarded one.
- R10: Parameter OUT_REG adds one register stage to the bypass output only. The bypass latency is 3 + OUT_REG cycles, while buffer writes and echo status stay at 3 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Ring symbol clock |
| rst_n | input | 1 | Active-low synchronous reset |
| node_id | input | SYM_W | Id of this node |
| lnk_pkt | input | 1 | Input symbol belongs to a packet (0 = idle) |
| lnk_sym | input | SYM_W | Input symbol data |
| buf_space | input | SPACE_W | Free symbol slots in the local input buffer |
| byp_pkt | output | 1 | Bypass output symbol is a packet symbol |
| byp_sym | output | SYM_W | Bypass output symbol data |
| buf_wr | output | 1 | Write strobe to the input buffer |
| buf_data | output | SYM_W | Symbol written to the input buffer |
| buf_sop | output | 1 | Marks the first symbol of a written packet |
| echo_vld | output | 1 | A local echo was consumed this cycle |
| echo_nack | output | 1 | Status of that echo (1 = nack) |
| echo_from | output | SYM_W | Node that sent that echo |

## Verification
Every result is tied to the cycle its input symbol was presented:
- Buffer writes appear 3 cycles later.
- An echo status strobe appears 3 cycles after the echo's first symbol.
- A bypass symbol appears 3 + OUT_REG cycles later.

The bench builds the whole input stream in advance and fills expected arrays indexed by input cycle. On every falling edge it compares each output against the entry that lies exactly that many cycles back, so an output that comes a cycle early or late fails as surely as a wrong value. The buffer-space boundary is exercised both at exactly the packet length and at one below it.

// File: rtl/ring_strip_pkg.sv
package ring_strip_pkg;

   // Per-packet handling chosen from the header
   typedef enum logic [1:0] {
      RT_FWD  = 2'd0,   // pass downstream
      RT_ACK  = 2'd1,   // strip, store, echo ack
      RT_NACK = 2'd2,   // strip, drop, echo nack
      RT_EAT  = 2'd3    // local echo: consume and report
   } route_e;

   localparam int CMD_CODE_LSB = 0;
   localparam int CMD_NACK_BIT = 4;
   localparam int HDR_SYMS     = 3;   // target, command, sender
   localparam int ECHO_SYMS    = 4;

endpackage

// File: rtl/rs_hdr_parse.sv
module rs_hdr_parse
   import ring_strip_pkg::*;
#(
   parameter int SYM_W   = 16,
   parameter int SPACE_W = 7,
   parameter int LEN_C0  = 4,
   parameter int LEN_C1  = 8,
   parameter int LEN_C2  = 16,
   parameter int LEN_C3  = 40
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SYM_W-1:0] node_id,
   input  logic             in_pkt,
   input  logic [SYM_W-1:0] in_sym,
   input  logic [SPACE_W-1:0] space,
   output logic             dec_pulse,
   output route_e           route,
   output logic [SYM_W-1:0] sender,
   output logic             echo_vld,
   output logic             echo_nack,
   output logic [SYM_W-1:0] echo_from
);

   localparam logic [1:0] POS_SAT = 2'd3;

   logic [1:0]       pos_q;
   logic [SYM_W-1:0] tgt_q;
   logic [SYM_W-1:0] cmd_q;
   logic             hdr_done;
   int               len_d;
   route_e           route_d;
   logic [1:0]       code;

   assign code     = cmd_q[CMD_CODE_LSB +: 2];
   assign hdr_done = in_pkt && (pos_q == 2'd2);

   // position within the current packet, cleared by every idle
   always_ff @(posedge clk) begin
      if (!rst_n)
         pos_q <= '0;
      else if (!in_pkt)
         pos_q <= '0;
      else if (pos_q != POS_SAT)
         pos_q <= pos_q + 2'd1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tgt_q <= '0;
         cmd_q <= '0;
      end else begin
         if (in_pkt && pos_q == 2'd0) tgt_q <= in_sym;
         if (in_pkt && pos_q == 2'd1) cmd_q <= in_sym;
      end
   end

   always_comb begin
      case (code)
         2'd0:    len_d = LEN_C0;
         2'd1:    len_d = LEN_C1;
         2'd2:    len_d = LEN_C2;
         default: len_d = LEN_C3;
      endcase
   end

   always_comb begin
      route_d = RT_FWD;
      if (tgt_q == node_id) begin
         if (code == 2'd0)
            route_d = RT_EAT;
         else if (int'(space) >= len_d)
            route_d = RT_ACK;
         else
            route_d = RT_NACK;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dec_pulse <= 1'b0;
         route     <= RT_FWD;
         sender    <= '0;
         echo_vld  <= 1'b0;
         echo_nack <= 1'b0;
         echo_from <= '0;
      end else begin
         dec_pulse <= hdr_done;
         echo_vld  <= hdr_done && (route_d == RT_EAT);
         if (hdr_done) begin
            route  <= route_d;
            sender <= in_sym;
         end
         if (hdr_done && route_d == RT_EAT) begin
            echo_nack <= cmd_q[CMD_NACK_BIT];
            echo_from <= in_sym;
         end
      end
   end

   // R8
   echo_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      echo_vld |=> !echo_vld);

   // R9
   dec_after_pkt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dec_pulse |-> $past(in_pkt));

   // R6
   room_on_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_pulse && route == RT_ACK) |-> (int'($past(space)) >= LEN_C1));

endmodule

// File: rtl/rs_delay.sv
module rs_delay #(
   parameter int SYM_W = 16,
   parameter int DEPTH = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_pkt,
   input  logic [SYM_W-1:0] in_sym,
   output logic             out_pkt,
   output logic [SYM_W-1:0] out_sym
);

   logic             pkt_q [DEPTH];
   logic [SYM_W-1:0] sym_q [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_stage
      if (i == 0) begin : g_head
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               pkt_q[0] <= 1'b0;
               sym_q[0] <= '0;
            end else begin
               pkt_q[0] <= in_pkt;
               sym_q[0] <= in_sym;
            end
         end
      end else begin : g_body
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               pkt_q[i] <= 1'b0;
               sym_q[i] <= '0;
            end else begin
               pkt_q[i] <= pkt_q[i-1];
               sym_q[i] <= sym_q[i-1];
            end
         end
      end
   end

   assign out_pkt = pkt_q[DEPTH-1];
   assign out_sym = sym_q[DEPTH-1];

endmodule

// File: rtl/rs_emit.sv
module rs_emit
   import ring_strip_pkg::*;
#(
   parameter int SYM_W = 16,
   parameter int IDX_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SYM_W-1:0] node_id,
   input  logic             st_pkt,
   input  logic [SYM_W-1:0] st_sym,
   input  logic             dec_pulse,
   input  route_e           route,
   input  logic [SYM_W-1:0] sender,
   output logic             ring_pkt,
   output logic [SYM_W-1:0] ring_sym,
   output logic             buf_wr,
   output logic [SYM_W-1:0] buf_data,
   output logic             buf_sop
);

   localparam logic [IDX_W-1:0] IDX_MAX = '1;

   logic [IDX_W-1:0] idx_q;
   logic [IDX_W-1:0] k;
   logic [SYM_W-1:0] echo_sym;
   logic             in_echo;

   assign k       = dec_pulse ? '0 : idx_q;
   assign in_echo = (int'(k) < ECHO_SYMS);

   always_ff @(posedge clk) begin
      if (!rst_n)
         idx_q <= '0;
      else if (dec_pulse)
         idx_q <= IDX_W'(1);
      else if (st_pkt && idx_q != IDX_MAX)
         idx_q <= idx_q + IDX_W'(1);
   end

   always_comb begin
      echo_sym = '0;
      case (int'(k))
         0: echo_sym = sender;
         1: echo_sym[CMD_NACK_BIT] = (route == RT_NACK);
         2: echo_sym = node_id;
         default: echo_sym = '0;
      endcase
   end

   always_comb begin
      ring_pkt = 1'b0;
      ring_sym = '0;
      if (st_pkt) begin
         case (route)
            RT_FWD: begin
               ring_pkt = 1'b1;
               ring_sym = st_sym;
            end
            RT_ACK, RT_NACK: begin
               if (in_echo) begin
                  ring_pkt = 1'b1;
                  ring_sym = echo_sym;
               end
            end
            default: ;
         endcase
      end
   end

   assign buf_wr   = st_pkt && (route == RT_ACK);
   assign buf_data = st_sym;
   assign buf_sop  = buf_wr && (k == '0);

   // R4
   echo_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ring_pkt && route != RT_FWD) |-> (int'(k) < ECHO_SYMS));

   // R6
   sop_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      buf_sop |=> !buf_sop);

   // R7
   nack_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (route == RT_NACK) |-> !buf_wr);

endmodule

// File: rtl/ring_strip_echo.sv
module ring_strip_echo
   import ring_strip_pkg::*;
#(
   parameter int SYM_W   = 16,
   parameter int SPACE_W = 7,
   parameter int LEN_C0  = 4,
   parameter int LEN_C1  = 8,
   parameter int LEN_C2  = 16,
   parameter int LEN_C3  = 40,
   parameter bit OUT_REG = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [SYM_W-1:0]   node_id,
   input  logic               lnk_pkt,
   input  logic [SYM_W-1:0]   lnk_sym,
   input  logic [SPACE_W-1:0] buf_space,
   output logic               byp_pkt,
   output logic [SYM_W-1:0]   byp_sym,
   output logic               buf_wr,
   output logic [SYM_W-1:0]   buf_data,
   output logic               buf_sop,
   output logic               echo_vld,
   output logic               echo_nack,
   output logic [SYM_W-1:0]   echo_from
);

   localparam int IDX_W = $clog2(LEN_C3 + 1);

   // elaboration-time parameter checks
   if (SYM_W < 8) begin : g_bad_width
      $error("SYM_W must leave room for the command status bit");
   end
   if (LEN_C0 != ECHO_SYMS) begin : g_bad_echo
      $error("code 0 length must equal the echo length");
   end
   if (LEN_C1 <= HDR_SYMS || LEN_C1 < ECHO_SYMS) begin : g_bad_short
      $error("data packets must be at least as long as an echo");
   end
   if (LEN_C2 < LEN_C1 || LEN_C3 < LEN_C2) begin : g_bad_order
      $error("length codes must be non-decreasing");
   end

   logic             st_pkt;
   logic [SYM_W-1:0] st_sym;
   logic             dec_pulse;
   route_e           route;
   logic [SYM_W-1:0] sender;
   logic             ring_pkt;
   logic [SYM_W-1:0] ring_sym;

   rs_hdr_parse #(
      .SYM_W(SYM_W), .SPACE_W(SPACE_W),
      .LEN_C0(LEN_C0), .LEN_C1(LEN_C1), .LEN_C2(LEN_C2), .LEN_C3(LEN_C3)
   ) u_parse (
      .clk(clk), .rst_n(rst_n), .node_id(node_id),
      .in_pkt(lnk_pkt), .in_sym(lnk_sym), .space(buf_space),
      .dec_pulse(dec_pulse), .route(route), .sender(sender),
      .echo_vld(echo_vld), .echo_nack(echo_nack), .echo_from(echo_from)
   );

   rs_delay #(.SYM_W(SYM_W), .DEPTH(HDR_SYMS)) u_delay (
      .clk(clk), .rst_n(rst_n),
      .in_pkt(lnk_pkt), .in_sym(lnk_sym),
      .out_pkt(st_pkt), .out_sym(st_sym)
   );

   rs_emit #(.SYM_W(SYM_W), .IDX_W(IDX_W)) u_emit (
      .clk(clk), .rst_n(rst_n), .node_id(node_id),
      .st_pkt(st_pkt), .st_sym(st_sym),
      .dec_pulse(dec_pulse), .route(route), .sender(sender),
      .ring_pkt(ring_pkt), .ring_sym(ring_sym),
      .buf_wr(buf_wr), .buf_data(buf_data), .buf_sop(buf_sop)
   );

   if (OUT_REG) begin : g_out_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            byp_pkt <= 1'b0;
            byp_sym <= '0;
         end else begin
            byp_pkt <= ring_pkt;
            byp_sym <= ring_sym;
         end
      end
   end else begin : g_out_comb
      assign byp_pkt = ring_pkt;
      assign byp_sym = ring_sym;
   end

   // R3
   idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !byp_pkt |-> (byp_sym == '0));

endmodule

// File: tb/ring_strip_echo_test.sv
module ring_strip_echo_test;

   localparam int CLK_PER = 10;
   localparam bit OUT_REG = 1'b1;
   localparam int LAT_BUF = 3;
   localparam int LAT_RING = 3 + int'(OUT_REG);
   localparam int N = 1024;
   localparam logic [15:0] MY_ID = 16'h0042;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        lnk_pkt = 1'b0;
   logic [15:0] lnk_sym = '0;
   logic [6:0]  buf_space = '0;
   logic        byp_pkt, buf_wr, buf_sop, echo_vld, echo_nack;
   logic [15:0] byp_sym, buf_data, echo_from;

   always #(CLK_PER/2) clk = ~clk;

   ring_strip_echo #(.OUT_REG(OUT_REG)) uut (
      .clk(clk), .rst_n(rst_n), .node_id(MY_ID),
      .lnk_pkt(lnk_pkt), .lnk_sym(lnk_sym), .buf_space(buf_space),
      .byp_pkt(byp_pkt), .byp_sym(byp_sym),
      .buf_wr(buf_wr), .buf_data(buf_data), .buf_sop(buf_sop),
      .echo_vld(echo_vld), .echo_nack(echo_nack), .echo_from(echo_from)
   );

   // stimulus and expected values, indexed by input cycle
   logic        in_p [N];
   logic [15:0] in_s [N];
   logic [6:0]  in_sp [N];
   logic        x_rp [N];
   logic [15:0] x_rs [N];
   string       x_rt [N];
   logic        x_w [N];
   logic [15:0] x_wd [N];
   logic        x_sop [N];
   string       x_wt [N];
   logic        x_ev [N];
   logic        x_en [N];
   logic [15:0] x_ef [N];
   int          wp = 0;
   int          checks = 0;
   int          errors = 0;
   bit          done = 1'b0;

   function automatic int len_of(input int code);
      case (code)
         0: return 4;
         1: return 8;
         2: return 16;
         default: return 40;
      endcase
   endfunction

   task automatic add_idle(input int n, input logic [6:0] spc);
      for (int i = 0; i < n; i++) begin
         in_p[wp] = 1'b0;
         in_s[wp] = 16'hA5A5 ^ 16'(wp);   // garbage on idles
         in_sp[wp] = spc;
         wp++;
      end
   endtask

   // one idle, then a packet
   task automatic add_pkt(input logic [15:0] tgt, input int code,
                          input logic [15:0] src, input logic nbit,
                          input logic [6:0] spc, input string ftag);
      int len = len_of(code);
      int p;
      bit local_hit = (tgt == MY_ID);
      bit ack = int'(spc) >= len;
      add_idle(1, spc);
      p = wp;
      for (int j = 0; j < len; j++) begin
         in_p[wp] = 1'b1;
         in_sp[wp] = spc;
         case (j)
            0: in_s[wp] = tgt;
            1: in_s[wp] = 16'h0300 | (16'(nbit) << 4) | 16'(code);
            2: in_s[wp] = src;
            default: in_s[wp] = 16'hD000 + 16'(wp);
         endcase
         if (!local_hit) begin
            x_rp[wp] = 1'b1; x_rs[wp] = in_s[wp]; x_rt[wp] = ftag;
         end else if (code == 0) begin
            x_rt[wp] = "R8";
         end else begin
            if (j < 4) begin
               x_rp[wp] = 1'b1;
               case (j)
                  0: x_rs[wp] = src;
                  1: x_rs[wp] = ack ? 16'h0000 : 16'h0010;
                  2: x_rs[wp] = MY_ID;
                  default: x_rs[wp] = 16'h0000;
               endcase
               x_rt[wp] = ack ? "R5/R6" : "R5/R7";
            end else begin
               x_rt[wp] = "R4";
            end
            if (ack) begin
               x_w[wp] = 1'b1; x_wd[wp] = in_s[wp]; x_sop[wp] = (j == 0);
               x_wt[wp] = "R6";
            end else begin
               x_wt[wp] = "R7";
            end
         end
         wp++;
      end
      if (local_hit && code == 0) begin
         x_ev[p] = 1'b1; x_en[p] = nbit; x_ef[p] = src;
      end
   endtask

   task automatic check_bit(input string tag, input string what,
                            input logic got, input logic exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s %s: got %b expected %b", tag, what, got, exp);
      end
   endtask

   task automatic check_word(input string tag, input string what,
                             input logic [15:0] got, input logic [15:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
      end
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      for (int i = 0; i < N; i++) begin
         in_p[i] = 1'b0; in_s[i] = '0; in_sp[i] = '0;
         x_rp[i] = 1'b0; x_rs[i] = '0; x_rt[i] = "R3";
         x_w[i] = 1'b0; x_wd[i] = '0; x_sop[i] = 1'b0; x_wt[i] = "R2";
         x_ev[i] = 1'b0; x_en[i] = 1'b0; x_ef[i] = '0;
      end
      add_idle(3, 7'd100);
      // R2: forwarded packets of every length, including a foreign echo
      add_pkt(16'h0011, 1, 16'h0007, 1'b0, 7'd100, "R2");
      add_pkt(16'h0012, 2, 16'h0008, 1'b0, 7'd100, "R2");
      add_pkt(16'h0013, 3, 16'h0009, 1'b0, 7'd100, "R2");
      add_pkt(16'h0014, 0, 16'h000A, 1'b1, 7'd100, "R2");
      add_idle(4, 7'd100);
      // R6: accepted stripping at each data length
      add_pkt(MY_ID, 1, 16'h0021, 1'b0, 7'd100, "R2");
      add_pkt(MY_ID, 2, 16'h0022, 1'b0, 7'd100, "R2");
      add_pkt(MY_ID, 3, 16'h0023, 1'b0, 7'd100, "R2");
      // R6/R7: space boundary
      add_pkt(MY_ID, 2, 16'h0031, 1'b0, 7'd16, "R2");
      add_pkt(MY_ID, 2, 16'h0032, 1'b0, 7'd15, "R2");
      add_pkt(MY_ID, 3, 16'h0033, 1'b0, 7'd0, "R2");
      add_pkt(MY_ID, 1, 16'h0034, 1'b0, 7'd7, "R2");
      add_pkt(MY_ID, 1, 16'h0035, 1'b0, 7'd8, "R2");
      // R8: local echoes, ack then nack
      add_pkt(MY_ID, 0, 16'h0051, 1'b0, 7'd0, "R2");
      add_pkt(MY_ID, 0, 16'h0052, 1'b1, 7'd0, "R2");
      // R9: back-to-back mixes with a single idle between
      add_pkt(MY_ID, 1, 16'h0061, 1'b0, 7'd50, "R9");
      add_pkt(16'h0099, 1, 16'h0062, 1'b0, 7'd50, "R9");
      add_pkt(MY_ID, 0, 16'h0063, 1'b1, 7'd50, "R9");
      add_pkt(16'h0098, 0, 16'h0064, 1'b0, 7'd50, "R9");
      add_pkt(MY_ID, 2, 16'h0065, 1'b0, 7'd3, "R9");
      add_pkt(16'h0097, 2, 16'h0066, 1'b0, 7'd3, "R9");
      add_idle(8, 7'd0);

      // R1: reset state
      repeat (3) @(posedge clk);
      @(negedge clk);
      check_bit("R1", "byp_pkt in reset", byp_pkt, 1'b0);
      check_word("R1", "byp_sym in reset", byp_sym, 16'h0000);
      check_bit("R1", "buf_wr in reset", buf_wr, 1'b0);
      check_bit("R1", "echo_vld in reset", echo_vld, 1'b0);
      rst_n = 1'b1;

      for (int m = 0; m < wp + LAT_RING + 1; m++) begin
         @(negedge clk);
         // outputs due from earlier inputs (R10: bypass latency 3+OUT_REG)
         if (m >= LAT_RING) begin
            check_bit({x_rt[m-LAT_RING], " R10"}, "byp_pkt", byp_pkt, x_rp[m-LAT_RING]);
            check_word({x_rt[m-LAT_RING], " R10"}, "byp_sym", byp_sym, x_rs[m-LAT_RING]);
         end else begin
            check_bit("R1", "byp_pkt after reset", byp_pkt, 1'b0);
         end
         if (m >= LAT_BUF) begin
            check_bit(x_wt[m-LAT_BUF], "buf_wr", buf_wr, x_w[m-LAT_BUF]);
            if (x_w[m-LAT_BUF]) begin
               check_word(x_wt[m-LAT_BUF], "buf_data", buf_data, x_wd[m-LAT_BUF]);
               check_bit(x_wt[m-LAT_BUF], "buf_sop", buf_sop, x_sop[m-LAT_BUF]);
            end
            check_bit("R8", "echo_vld", echo_vld, x_ev[m-LAT_BUF]);
            if (x_ev[m-LAT_BUF]) begin
               check_bit("R8", "echo_nack", echo_nack, x_en[m-LAT_BUF]);
               check_word("R8", "echo_from", echo_from, x_ef[m-LAT_BUF]);
            end
         end else begin
            check_bit("R1", "buf_wr after reset", buf_wr, 1'b0);
            check_bit("R1", "echo_vld after reset", echo_vld, 1'b0);
         end
         if (m < wp) begin
            lnk_pkt = in_p[m];
            lnk_sym = in_s[m];
            buf_space = in_sp[m];
         end else begin
            lnk_pkt = 1'b0;
            lnk_sym = 16'h1234;
         end
      end
      done = 1'b1;
      finish_run();
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run did not complete");
         finish_run();
      end
   end

endmodule